// File: doc/BRIEF.md
# Clause 22 PHY Management Controller with AXI4-Lite Register Access

This block lets a processor or a bring-up state machine read and write the registers of an external Ethernet PHY. It is an AXI4-Lite slave with four registers: a setup register that enables the management bus and sets the clock divisor, a command register, a transmit-data register and a receive-data register. When a command word with the initiate bit is written, the block generates the management clock and shifts out one complete Clause 22 frame. For a read, it releases the data line during the turnaround and data phases and captures the sixteen bits the PHY returns.

A write transaction has two steps. The 16-bit value goes into the transmit-data register first, and then the command word is written with the opcode and the initiate bit. Completion is reported in two places: the ready flag in the command register and the ready flag beside the captured value in the receive-data register. Software polls either one. The divisor sets the rate of the management clock, which runs only while a frame is being sent.

Top module: `mdio_axil_ctrl`

## Requirements
- R1: After reset, command readback is 0x0000_0080 (ready at bit 7), receive readback is 0x0001_0000 (ready at bit 16), setup readback is 0, MDC is low and the MDIO output enable is low.
- R2: The write address and write data channels are accepted in any order. Every B and R response is OKAY (00). Reads of any offset other than 0x500, 0x504, 0x508 and 0x50C return zero.
- R3: Setup register at 0x500: bit 6 enables the management bus and bits 5:0 hold the divisor. Both fields read back as written.
- R4: MDC has a period of 2×(d+1) bus clocks, where d is the divisor, and a divisor of 0 behaves as 1.
- R5: Command register at 0x504 holds the PHY address in bits 28:24, the register address in bits 20:16, the opcode in bits 15:14 and initiate in bit 11. Opcode 01 sends a write frame, MSB first: 32 ones, 01, the opcode, the 5-bit PHY address, the 5-bit register address, turnaround 10, and the 16-bit value taken from 0x508.
- R6: Opcode 10 sends a read frame. MDIO output enable is low for both turnaround bits and all 16 data bits. The bits are sampled on MDC rising edges and read back in bits 15:0 of 0x50C.
- R7: Command bit 7 and receive bit 16 read 0 from the accepted initiate write until the frame ends, and then read 1.
- R8: An initiate write that arrives while a frame is in progress is ignored. It still gets an OKAY response, it starts no second frame, and the stored command fields keep their values.
- R9: An initiate write made while the enable bit is 0 starts no frame, produces no MDC edge, and leaves both ready flags at 1.
- R10: MDIO output changes only after an MDC falling edge. After a frame, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The assertions assume that the bus master holds VALID and its payload stable until the handshake, and that the PHY changes MDIO only near the MDC falling edge, never at a rising edge. The bench drives the AXI channels only on negative clock edges and keeps each one valid until READY has been seen. Its PHY model updates the read bit on each MDC falling edge and otherwise leaves the line pulled high, so every sampled bit has been stable for a full half period.

// File: rtl/mdio_axil_pkg.sv
`timescale 1ns/1ps
package mdio_axil_pkg;

   localparam logic [11:0] OFS_SETUP = 12'h500;
   localparam logic [11:0] OFS_CMD   = 12'h504;
   localparam logic [11:0] OFS_TXD   = 12'h508;
   localparam logic [11:0] OFS_RXD   = 12'h50C;

   localparam int SETUP_EN_BIT = 6;
   localparam int CMD_GO_BIT   = 11;

   localparam logic [1:0] OP_WR     = 2'b01;
   localparam logic [1:0] OP_RD     = 2'b10;
   localparam logic [1:0] START_SEQ = 2'b01;
   localparam logic [1:0] TA_DRIVE  = 2'b10;
   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef struct packed {
      logic [4:0] phy;
      logic [4:0] regad;
      logic [1:0] op;
   } mdio_cmd_t;

endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             mdc_o,
   output logic             rise_o,
   output logic             fall_o
);

   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(1);

   generate
      if (DIV_W < 1 || DIV_W > 6) begin : g_bad_div
         $error("mdio_clk_gen: DIV_W must be 1..6");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;
   logic             tick;

   assign lim    = (div_i == '0) ? MIN_DIV : div_i;
   assign tick   = run_i && (cnt == lim);
   assign rise_o = tick && !mdc_o;
   assign fall_o = tick && mdc_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         mdc_o <= 1'b0;
      end else if (!run_i) begin
         cnt   <= '0;
         mdc_o <= 1'b0;
      end else if (tick) begin
         cnt   <= '0;
         mdc_o <= !mdc_o;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   // R4: MDC only moves on a divider tick
   p_mdc_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick) |=> $stable(mdc_o));

endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
   import mdio_axil_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  mdio_cmd_t   cmd_i,
   input  logic [15:0] txd_i,
   input  logic        rise_i,
   input  logic        fall_i,
   input  logic        mdio_i,
   output logic        busy_o,
   output logic        mdio_o,
   output logic        mdio_oe_o,
   output logic [15:0] rd_data_o
);

   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int TA_POS    = PRE_LEN + 14;
   localparam int DATA_POS  = PRE_LEN + 16;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

   generate
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("mdio_frame_engine: PRE_LEN must be 1..64");
      end
   endgenerate

   logic [FRAME_LEN-1:0] shreg;
   logic [FRAME_LEN-1:0] frame;
   logic [IDX_W-1:0]     idx;
   logic [IDX_W-1:0]     idx_nxt;
   logic                 rd_q;
   logic                 cmd_rd;
   logic [15:0]          cap;

   assign cmd_rd  = (cmd_i.op == OP_RD);
   assign idx_nxt = idx + 1'b1;
   assign frame   = {{PRE_LEN{1'b1}}, START_SEQ, cmd_i.op, cmd_i.phy, cmd_i.regad,
                     (cmd_rd ? 2'b11 : TA_DRIVE), (cmd_rd ? 16'h0000 : txd_i)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '1;
         idx       <= '0;
         rd_q      <= 1'b0;
         cap       <= '0;
         busy_o    <= 1'b0;
         mdio_o    <= 1'b1;
         mdio_oe_o <= 1'b0;
         rd_data_o <= '0;
      end else if (start_i && !busy_o) begin
         shreg     <= frame;
         idx       <= '0;
         rd_q      <= cmd_rd;
         busy_o    <= 1'b1;
         mdio_o    <= frame[FRAME_LEN-1];
         mdio_oe_o <= 1'b1;
      end else if (busy_o) begin
         if (rise_i && rd_q && (idx >= DATA_IDX)) begin
            cap <= {cap[14:0], mdio_i};
         end
         if (fall_i) begin
            if (idx == LAST_IDX) begin
               busy_o    <= 1'b0;
               mdio_o    <= 1'b1;
               mdio_oe_o <= 1'b0;
               if (rd_q) begin
                  rd_data_o <= cap;
               end
            end else begin
               idx       <= idx_nxt;
               shreg     <= {shreg[FRAME_LEN-2:0], 1'b1};
               mdio_o    <= shreg[FRAME_LEN-2];
               mdio_oe_o <= !(rd_q && (idx_nxt >= TA_IDX));
            end
         end
      end
   end

   // R10: data line moves only after a falling MDC edge (or at frame load)
   p_mdio_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $past(fall_i || start_i));

   // R6: line released for turnaround and data of a read
   p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rd_q && (idx >= TA_IDX)) |-> !mdio_oe_o);

   // R10: nothing driven when idle
   p_idle_undriven_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mdio_oe_o);

endmodule

// File: rtl/mdio_axil_regs.sv
`timescale 1ns/1ps
module mdio_axil_regs
   import mdio_axil_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DIV_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [31:0]       wdata,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [31:0]       rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic              busy_i,
   input  logic [15:0]       rd_data_i,
   output logic              start_o,
   output mdio_cmd_t         cmd_o,
   output logic [15:0]       txd_o,
   output logic [DIV_W-1:0]  div_o
);

   localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(OFS_SETUP);
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFS_RXD);

   generate
      if (ADDR_W < 11) begin : g_bad_aw
         $error("mdio_axil_regs: ADDR_W must reach offset 0x50C");
      end
   endgenerate

   logic              aw_held, w_held;
   logic [ADDR_W-1:0] aw_q;
   logic [31:0]       w_q;
   logic              en_q;
   logic              wr_fire;
   logic              ready;
   logic [31:0]       rd_mux;
   logic              unused_wq;

   assign awready   = !aw_held && !bvalid;
   assign wready    = !w_held && !bvalid;
   assign arready   = !rvalid;
   assign bresp     = RESP_OKAY;
   assign rresp     = RESP_OKAY;
   assign wr_fire   = aw_held && w_held && !bvalid;
   assign ready     = !busy_i && !start_o;
   assign unused_wq = ^{w_q[31:29], w_q[23:21]};

   always_comb begin
      rd_mux = '0;
      if (araddr == A_SETUP) begin
         rd_mux = {25'b0, en_q, 6'(div_o)};
      end else if (araddr == A_CMD) begin
         rd_mux = {3'b0, cmd_o.phy, 3'b0, cmd_o.regad, cmd_o.op, 6'b0, ready, 7'b0};
      end else if (araddr == A_TXD) begin
         rd_mux = {16'b0, txd_o};
      end else if (araddr == A_RXD) begin
         rd_mux = {15'b0, ready, rd_data_i};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held <= 1'b0;
         w_held  <= 1'b0;
         aw_q    <= '0;
         w_q     <= '0;
         bvalid  <= 1'b0;
         rvalid  <= 1'b0;
         rdata   <= '0;
         en_q    <= 1'b0;
         div_o   <= '0;
         cmd_o   <= '0;
         txd_o   <= '0;
         start_o <= 1'b0;
      end else begin
         start_o <= 1'b0;
         if (awvalid && awready) begin
            aw_held <= 1'b1;
            aw_q    <= awaddr;
         end
         if (wvalid && wready) begin
            w_held <= 1'b1;
            w_q    <= wdata;
         end
         if (bvalid && bready) begin
            bvalid <= 1'b0;
         end
         if (wr_fire) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b1;
            if (aw_q == A_SETUP) begin
               en_q  <= w_q[SETUP_EN_BIT];
               div_o <= w_q[DIV_W-1:0];
            end else if (aw_q == A_CMD) begin
               if (ready) begin
                  cmd_o   <= '{phy: w_q[28:24], regad: w_q[20:16], op: w_q[15:14]};
                  start_o <= w_q[CMD_GO_BIT] && en_q;
               end
            end else if (aw_q == A_TXD) begin
               txd_o <= w_q[15:0];
            end
         end
         if (rvalid && rready) begin
            rvalid <= 1'b0;
         end
         if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rd_mux;
         end
      end
   end

   // R2: responses are held until accepted
   p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid);

   p_rvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> (rvalid && $stable(rdata)));

   // R8: a frame is only launched into an idle engine
   p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !busy_i);

endmodule

// File: rtl/mdio_axil_ctrl.sv
`timescale 1ns/1ps
module mdio_axil_ctrl
   import mdio_axil_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DIV_W   = 6,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [31:0]       s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);

   logic             busy;
   logic             start;
   logic             rise_stb, fall_stb;
   mdio_cmd_t        cmd;
   logic [15:0]      txd;
   logic [15:0]      rd_data;
   logic [DIV_W-1:0] div;

   mdio_axil_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .busy_i(busy), .rd_data_i(rd_data),
      .start_o(start), .cmd_o(cmd), .txd_o(txd), .div_o(div)
   );

   mdio_clk_gen #(.DIV_W(DIV_W)) clkgen_i (
      .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div),
      .mdc_o(mdc_o), .rise_o(rise_stb), .fall_o(fall_stb)
   );

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) engine_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .txd_i(txd),
      .rise_i(rise_stb), .fall_i(fall_stb), .mdio_i(mdio_i),
      .busy_o(busy), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .rd_data_o(rd_data)
   );

   // R10: clock parked low whenever no frame is running
   p_idle_mdc_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc_o);

   // R2: every response is OKAY
   p_okay_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00));

endmodule

// File: tb/mdio_axil_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_axil_ctrl_tb_top;

   localparam logic [11:0] A_SETUP = 12'h500;
   localparam logic [11:0] A_CMD   = 12'h504;
   localparam logic [11:0] A_TXD   = 12'h508;
   localparam logic [11:0] A_RXD   = 12'h50C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] awaddr = '0;
   logic        awvalid = 1'b0;
   logic        awready;
   logic [31:0] wdata = '0;
   logic        wvalid = 1'b0;
   logic        wready;
   logic [1:0]  bresp;
   logic        bvalid;
   logic        bready = 1'b1;
   logic [11:0] araddr = '0;
   logic        arvalid = 1'b0;
   logic        arready;
   logic [31:0] rdata;
   logic [1:0]  rresp;
   logic        rvalid;
   logic        rready = 1'b1;
   logic        mdc, mdio_o, mdio_oe;
   logic        phy_drv = 1'b1;
   logic        mdio_i;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int exp_period = 4;
   int rise_count = 0;
   logic [15:0] phy_val = '0;
   logic [127:0] exp_q[$];

   assign mdio_i = mdio_oe ? mdio_o : phy_drv;

   always #10 clk = ~clk;

   mdio_axil_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- PHY-side monitor and scoreboard ----------------
   int          nbits = 0;
   logic [63:0] obits = '0;
   logic [63:0] ooe = '0;
   time         t_last = 0;

   always @(posedge mdc) begin
      rise_count++;
      if (nbits == 1) begin
         chk(((($time - t_last) / 20) == exp_period), "R4", "MDC period",
             64'(($time - t_last) / 20), 64'(exp_period));
      end
      t_last = $time;
      obits[63-nbits] = mdio_oe ? mdio_o : 1'b0;
      ooe[63-nbits]   = mdio_oe;
      nbits++;
      if (nbits == 64) begin
         nbits = 0;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8/R9", "unexpected frame", obits, 64'h0);
         end else begin
            logic [127:0] item;
            logic [63:0]  ef, em;
            item = exp_q.pop_front();
            ef = item[127:64];
            em = item[63:0];
            if (em == 64'hFFFF_FFFF_FFFF_FFFF)
               chk((obits == ef) && (ooe == em), "R5", "write frame bits", obits, ef);
            else
               chk(((obits & em) == (ef & em)) && (ooe == em), "R6", "read frame drive", ooe, em);
         end
      end
   end

   always @(negedge mdc) begin
      if (nbits >= 48 && nbits < 64 && obits[29:28] == 2'b10)
         phy_drv = phy_val[63-nbits];
      else
         phy_drv = 1'b1;
   end

   // ---------------- AXI driver tasks ----------------
   task automatic send_aw(input logic [11:0] a);
      bit hs;
      awaddr = a; awvalid = 1'b1;
      forever begin
         hs = awready;
         @(negedge clk);
         if (hs) break;
      end
      awvalid = 1'b0;
   endtask

   task automatic send_w(input logic [31:0] d);
      bit hs;
      wdata = d; wvalid = 1'b1;
      forever begin
         hs = wready;
         @(negedge clk);
         if (hs) break;
      end
      wvalid = 1'b0;
   endtask

   task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input int ord);
      @(negedge clk);
      if (ord == 1) begin
         send_aw(a); @(negedge clk); send_w(d);
      end else if (ord == 2) begin
         send_w(d); @(negedge clk); send_aw(a);
      end else begin
         fork
            send_aw(a);
            send_w(d);
         join
      end
      while (!bvalid) @(negedge clk);
      chk(bresp == 2'b00, "R2", "write response OKAY", 64'(bresp), 64'h0);
      @(negedge clk);
   endtask

   task automatic axi_rd(input logic [11:0] a, output logic [31:0] d);
      bit hs;
      @(negedge clk);
      araddr = a; arvalid = 1'b1;
      forever begin
         hs = arready;
         @(negedge clk);
         if (hs) break;
      end
      arvalid = 1'b0;
      while (!rvalid) @(negedge clk);
      d = rdata;
      if (rresp != 2'b00) chk(1'b0, "R2", "read response OKAY", 64'(rresp), 64'h0);
      @(negedge clk);
   endtask

   task automatic set_setup(input bit en, input logic [5:0] dv);
      logic [31:0] d;
      axi_wr(A_SETUP, {25'b0, en, dv}, 0);
      exp_period = 2 * (((dv == 0) ? 1 : int'(dv)) + 1);
      axi_rd(A_SETUP, d);
      chk(d == {25'b0, en, dv}, "R3", "setup readback", 64'(d), 64'({25'b0, en, dv}));
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      int n = 0;
      do begin
         axi_rd(A_CMD, d);
         n++;
      end while (!d[7] && n < 5000);
   endtask

   function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] ra);
      return {3'b0, phy, 3'b0, ra, op, 2'b0, 1'b1, 11'b0};
   endfunction

   task automatic push_exp(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] v);
      logic [63:0] f, m;
      if (op == 2'b10) begin
         f = {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b00, 16'h0000};
         m = {{46{1'b1}}, {18{1'b0}}};
      end else begin
         f = {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, v};
         m = '1;
      end
      exp_q.push_back({f, m});
   endtask

   task automatic do_frame(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] v, input int ord);
      logic [31:0] d;
      if (op == 2'b10) phy_val = v;
      else axi_wr(A_TXD, {16'h0, v}, ord);
      push_exp(op, phy, ra, v);
      axi_wr(A_CMD, cmd_word(op, phy, ra), ord);
      axi_rd(A_CMD, d);
      chk(d[7] == 1'b0, "R7", "command ready low while busy", 64'(d[7]), 64'h0);
      axi_rd(A_RXD, d);
      chk(d[16] == 1'b0, "R7", "receive ready low while busy", 64'(d[16]), 64'h0);
      wait_idle();
      axi_rd(A_RXD, d);
      chk(d[16] == 1'b1, "R7", "receive ready high after frame", 64'(d[16]), 64'h1);
      if (op == 2'b10)
         chk(d[15:0] == v, "R6", "captured read value", 64'(d[15:0]), 64'(v));
      chk(!mdc && !mdio_oe, "R10", "idle mdc/oe low", 64'({mdc, mdio_oe}), 64'h0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] d;
      int rc;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      axi_rd(A_CMD, d);
      chk(d == 32'h0000_0080, "R1", "reset command readback", 64'(d), 64'h80);
      axi_rd(A_RXD, d);
      chk(d == 32'h0001_0000, "R1", "reset receive readback", 64'(d), 64'h10000);
      axi_rd(A_SETUP, d);
      chk(d == 32'h0, "R1", "reset setup readback", 64'(d), 64'h0);
      chk(!mdc && !mdio_oe, "R1", "reset mdc/oe", 64'({mdc, mdio_oe}), 64'h0);

      // R2 unmapped offsets
      axi_wr(12'h510, 32'hDEAD_BEEF, 1);
      axi_rd(12'h510, d);
      chk(d == 0, "R2", "unmapped 0x510 reads zero", 64'(d), 64'h0);
      axi_rd(12'h000, d);
      chk(d == 0, "R2", "unmapped 0x000 reads zero", 64'(d), 64'h0);

      // R9 disabled: no frame
      set_setup(1'b0, 6'd2);
      rc = rise_count;
      axi_wr(A_CMD, cmd_word(2'b01, 5'd1, 5'd0), 0);
      axi_rd(A_CMD, d);
      chk(d[7] == 1'b1, "R9", "ready stays high when disabled", 64'(d[7]), 64'h1);
      repeat (200) @(negedge clk);
      chk(rise_count == rc, "R9", "no MDC edge when disabled", 64'(rise_count), 64'(rc));
      axi_rd(A_RXD, d);
      chk(d[16] == 1'b1, "R9", "receive ready high when disabled", 64'(d[16]), 64'h1);

      // R3/R4/R5 write frames, various orders and divisors
      set_setup(1'b1, 6'd2);
      do_frame(2'b01, 5'd3, 5'd13, 16'h001F, 0);
      do_frame(2'b01, 5'd31, 5'd0, 16'hFFFF, 1);
      set_setup(1'b1, 6'd0);
      do_frame(2'b01, 5'd0, 5'd31, 16'h0000, 2);
      set_setup(1'b1, 6'd1);
      do_frame(2'b01, 5'd1, 5'd20, 16'h29C7, 0);

      // R6 read frames
      set_setup(1'b1, 6'd3);
      do_frame(2'b10, 5'd3, 5'd1, 16'hA5C3, 0);
      do_frame(2'b10, 5'd7, 5'd5, 16'h8001, 2);

      // R8 initiate while busy is ignored
      axi_wr(A_TXD, 32'h0000_1140, 0);
      push_exp(2'b01, 5'd4, 5'd9, 16'h1140);
      axi_wr(A_CMD, cmd_word(2'b01, 5'd4, 5'd9), 0);
      axi_wr(A_CMD, cmd_word(2'b10, 5'd17, 5'd22), 1);
      wait_idle();
      axi_rd(A_CMD, d);
      chk(d == 32'h0409_4080, "R8", "command fields kept after busy write", 64'(d), 64'h04094080);
      repeat (100) @(negedge clk);
      chk(exp_q.size() == 0, "R8", "single frame for busy initiate", 64'(exp_q.size()), 64'h0);

      // R3 value used for bring-up: 0x5F
      set_setup(1'b1, 6'h1F);
      do_frame(2'b10, 5'd1, 5'd2, 16'h2000, 0);

      chk(exp_q.size() == 0, "R5", "all expected frames seen", 64'(exp_q.size()), 64'h0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule